// File: doc/BRIEF.md
# Strap Latch and Output Clock Gating Controller

This block sits between a clock synthesizer core and the clock output pins. Five of those pins serve two purposes. While power-on reset is held, they are inputs that carry board straps: four frequency-select bits and one AGP rate select. Once reset has been released, the same pins carry buffered clocks.

A two-step start-up sequence freezes the straps and only then turns on the pin drivers. The sequence runs through three states:

- `ST_SAMPLE` is held for as long as reset is asserted.
- `ST_LOCK` lasts one cycle and is entered at the first rising edge after reset is released.
- `ST_DRIVE` follows `ST_LOCK` and never exits.

The block also holds five byte-wide enable registers, written and read through a simple byte port. Each of 28 clock outputs passes through its own gate. The gate changes state only while that output's source is low, so switching an output off or on never produces a short pulse.

One output can run either at the rate of the 48 MHz source or at half that rate. The rate switch also waits for a quiet low phase. The latched frequency-select code is presented on a port and can be read back, inverted, through the register port.

Top module: `strap_clk_gate_top`

## Requirements
- R1: While `rst_n` is low, the strap latch copies `strap_pad_in` at every rising clock edge. The value taken at the last edge before release is kept until the next reset, and later changes on `strap_pad_in` have no effect.
- R2: `strap_pad_oe` is low during reset and at the first rising edge after release. It is high from the second rising edge after release onwards. `strap_pad_out` is all zero while `strap_pad_oe` is low.
- R3: `fs_code[k]` equals the latched level of `strap_pad_in[k]` for k = 0..3, and `agp_sel` equals the latched level of `strap_pad_in[4]`.
- R4: A read of address 5 returns the inverse of `fs_code` in bits 7..4. Writes to those bits are ignored.
- R5: Each enable bit sits at a fixed address and bit position:
  - Address 1: bit 3 enables `cpu_clk_t[0]`, bit 2 enables `cpu_clk_c`, bit 1 enables `cpu_clk_t[1]`.
  - Address 2: bit 0 enables pad 1 (free-running PCI clock), bit 1 enables pad 2 (PCI clock 0), bits 5..2 enable `pci_clk[4:1]`.
  - Address 3: bits 7..0 enable `sdram_clk[7:0]`.
  - Address 4: bits 4..0 enable `sdram_clk[12:8]`, bit 5 enables pad 0 (48 MHz), bit 6 enables `clk_24_48`.
  - Address 5: bits 1..0 enable `agp_clk[1:0]`, bit 2 enables pad 3 (REF0), bit 3 enables pad 4 (REF1).
- R6: An output whose enable bit is 1 follows its source, and `cpu_clk_c` follows the inverted CPU source. An output whose enable bit is 0 stays low. The sources are:
  - `cpu_clk_t` uses `cpu_src`; `sdram_clk` uses `sdram_src`; `agp_clk` uses `agp_src`.
  - `pci_clk` and pads 1 and 2 use `pci_src`.
  - Pads 3 and 4 use `ref_src`.
  - Pad 0 uses `usb_src`.
- R7: After reset, addresses 1 to 4 read 0xFF and address 5 reads 0xF in bits 3..0.
- R8: Address 1 bit 7 selects the `clk_24_48` source. When it is 1, the source toggles once per rising edge of `usb_src`, giving half the rate. When it is 0, the source follows `usb_src`.
- R9: A gated output rises or falls only when its source does. A change of enable bit takes effect only at a rising clock edge where the source is low, so an output disabled while high completes its pulse.
- R10: Bits that gate nothing at addresses 1, 2 and 4 read back as written. Addresses 0, 6 and 7 read 0, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Power-on reset, active low |
| cpu_src | input | 1 | CPU clock source |
| sdram_src | input | 1 | SDRAM clock source |
| pci_src | input | 1 | PCI clock source |
| agp_src | input | 1 | AGP clock source |
| ref_src | input | 1 | Reference clock source |
| usb_src | input | 1 | 48 MHz clock source |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| strap_pad_in | input | 5 | Pad levels seen as inputs |
| strap_pad_out | output | 5 | Pad clock drive values |
| strap_pad_oe | output | 1 | Pad driver enable |
| cpu_clk_t | output | 2 | CPU clocks, true phase |
| cpu_clk_c | output | 1 | CPU clock, complement phase |
| sdram_clk | output | 13 | SDRAM clocks |
| pci_clk | output | 4 | PCI clocks 4..1 |
| agp_clk | output | 2 | AGP clocks |
| clk_24_48 | output | 1 | Selectable 24/48 MHz clock |
| fs_code | output | 4 | Latched frequency-select code |
| agp_sel | output | 1 | Latched AGP rate select |

## Verification
Two things can land on the same clock edge: a register write that flips an enable bit, and the source of that output being high. The bench provokes this by waiting for a rise of the slow reference source and then writing at once, so the enable register changes while the source is high. It then checks that the pad keeps its pulse until the source falls and stays low afterwards. The rate switch of `clk_24_48` is handled the same way, and per-lane assertions reject any edge on an output that has no matching edge on its source.

// File: rtl/strap_clk_pkg.sv
package strap_clk_pkg;

    localparam int STRAP_W = 5;
    localparam int FS_W    = 4;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 3;
    localparam int N_SDRAM = 13;
    localparam int N_PCI   = 5;
    localparam int N_AGP   = 2;
    localparam int N_LANE  = 28;

    // lane positions in the gate bank
    localparam int L_CPU_T0  = 0;
    localparam int L_CPU_C0  = 1;
    localparam int L_CPU_T1  = 2;
    localparam int L_PCI_F   = 3;
    localparam int L_PCI0    = 4;
    localparam int L_SDRAM0  = L_PCI0 + N_PCI;
    localparam int L_CLK48   = L_SDRAM0 + N_SDRAM;
    localparam int L_CLK2448 = L_CLK48 + 1;
    localparam int L_REF0    = L_CLK2448 + 1;
    localparam int L_REF1    = L_REF0 + 1;
    localparam int L_AGP0    = L_REF1 + 1;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CPU  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PCI  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SDLO = 3'd3;
    localparam logic [ADDR_W-1:0] A_SDHI = 3'd4;
    localparam logic [ADDR_W-1:0] A_MISC = 3'd5;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LOCK   = 2'd1,
        ST_DRIVE  = 2'd2
    } boot_state_t;

endpackage

// File: rtl/strap_boot_fsm.sv
module strap_boot_fsm
    import strap_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               drive_en
);

    boot_state_t state_q;
    boot_state_t state_d;

    // strap capture: open while reset is held, frozen after
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= pad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = ST_LOCK;
            ST_LOCK:   state_d = ST_DRIVE;
            ST_DRIVE:  state_d = ST_DRIVE;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        drive_en = 1'b0;
        unique case (state_q)
            ST_SAMPLE: drive_en = 1'b0;
            ST_LOCK:   drive_en = 1'b0;
            ST_DRIVE:  drive_en = 1'b1;
            default:   drive_en = 1'b0;
        endcase
    end

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SAMPLE) |-> $stable(strap_q)); // R1

    AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !drive_en); // R2

    AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> $past(rst_n)); // R2

endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
    import strap_clk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [FS_W-1:0]   fs_in,
    output logic [REG_W-1:0]  rdata,
    output logic [N_LANE-1:0] lane_en,
    output logic              sel_half
);

    logic [REG_W-1:0] cpu_q;
    logic [REG_W-1:0] pci_q;
    logic [REG_W-1:0] sdlo_q;
    logic [REG_W-1:0] sdhi_q;
    logic [FS_W-1:0]  misc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_q  <= '1;
            pci_q  <= '1;
            sdlo_q <= '1;
            sdhi_q <= '1;
            misc_q <= '1;
        end else if (wr) begin
            case (addr)
                A_CPU:   cpu_q  <= wdata;
                A_PCI:   pci_q  <= wdata;
                A_SDLO:  sdlo_q <= wdata;
                A_SDHI:  sdhi_q <= wdata;
                A_MISC:  misc_q <= wdata[FS_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_CPU:   rdata = cpu_q;
            A_PCI:   rdata = pci_q;
            A_SDLO:  rdata = sdlo_q;
            A_SDHI:  rdata = sdhi_q;
            A_MISC:  rdata = {~fs_in, misc_q};
            default: rdata = '0;
        endcase
    end

    always_comb begin
        lane_en                      = '0;
        lane_en[L_CPU_T0]            = cpu_q[3];
        lane_en[L_CPU_C0]            = cpu_q[2];
        lane_en[L_CPU_T1]            = cpu_q[1];
        lane_en[L_PCI_F]             = pci_q[0];
        lane_en[L_PCI0 +: N_PCI]     = pci_q[N_PCI:1];
        lane_en[L_SDRAM0 +: REG_W]   = sdlo_q;
        lane_en[L_SDRAM0+REG_W +: N_SDRAM-REG_W] = sdhi_q[N_SDRAM-REG_W-1:0];
        lane_en[L_CLK48]             = sdhi_q[5];
        lane_en[L_CLK2448]           = sdhi_q[6];
        lane_en[L_REF0]              = misc_q[2];
        lane_en[L_REF1]              = misc_q[3];
        lane_en[L_AGP0 +: N_AGP]     = misc_q[N_AGP-1:0];
        sel_half                     = cpu_q[7];
    end

endmodule

// File: rtl/half_rate_mux.sv
module half_rate_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic base_src,
    input  logic sel_half,
    output logic mux_src
);

    logic prev_q;
    logic half_q;
    logic sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            half_q <= 1'b0;
            sel_q  <= 1'b1;
        end else begin
            prev_q <= base_src;
            if (base_src && !prev_q) begin
                half_q <= ~half_q;
            end
            // swap only when both candidates are low
            if (!base_src && !half_q) begin
                sel_q <= sel_half;
            end
        end
    end

    assign mux_src = sel_q ? half_q : base_src;

    AST_MUX_RISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mux_src) |-> ($rose(base_src) || $rose(half_q))); // R8

    AST_MUX_FALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mux_src) |-> ($fell(base_src) || $fell(half_q))); // R8

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] src,
    input  logic [LANES-1:0] en,
    output logic [LANES-1:0] gated
);

    logic [LANES-1:0] gate_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gate_q[i] <= 1'b1;
            end else if (!src[i]) begin
                gate_q[i] <= en[i];
            end
        end

        assign gated[i] = src[i] & gate_q[i];

        AST_NO_RUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gated[i]) |-> $rose(src[i])); // R9

        AST_NO_RUNT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gated[i]) |-> $fell(src[i])); // R9
    end

endmodule

// File: rtl/strap_clk_gate_top.sv
module strap_clk_gate_top
    import strap_clk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_src,
    input  logic               sdram_src,
    input  logic               pci_src,
    input  logic               agp_src,
    input  logic               ref_src,
    input  logic               usb_src,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [STRAP_W-1:0] strap_pad_in,
    output logic [STRAP_W-1:0] strap_pad_out,
    output logic               strap_pad_oe,
    output logic [1:0]         cpu_clk_t,
    output logic               cpu_clk_c,
    output logic [N_SDRAM-1:0] sdram_clk,
    output logic [N_PCI-2:0]   pci_clk,
    output logic [N_AGP-1:0]   agp_clk,
    output logic               clk_24_48,
    output logic [FS_W-1:0]    fs_code,
    output logic               agp_sel
);

    logic [STRAP_W-1:0] strap_q;
    logic               drive_en;
    logic [N_LANE-1:0]  lane_en;
    logic [N_LANE-1:0]  lane_src;
    logic [N_LANE-1:0]  lane_out;
    logic               sel_half;
    logic               mux_src;

    strap_boot_fsm u_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (strap_pad_in),
        .strap_q  (strap_q),
        .drive_en (drive_en)
    );

    clk_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .fs_in    (strap_q[FS_W-1:0]),
        .rdata    (reg_rdata),
        .lane_en  (lane_en),
        .sel_half (sel_half)
    );

    half_rate_mux u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_src (usb_src),
        .sel_half (sel_half),
        .mux_src  (mux_src)
    );

    always_comb begin
        lane_src                    = '0;
        lane_src[L_CPU_T0]          = cpu_src;
        lane_src[L_CPU_C0]          = ~cpu_src;
        lane_src[L_CPU_T1]          = cpu_src;
        lane_src[L_PCI_F]           = pci_src;
        lane_src[L_PCI0 +: N_PCI]   = {N_PCI{pci_src}};
        lane_src[L_SDRAM0 +: N_SDRAM] = {N_SDRAM{sdram_src}};
        lane_src[L_CLK48]           = usb_src;
        lane_src[L_CLK2448]         = mux_src;
        lane_src[L_REF0]            = ref_src;
        lane_src[L_REF1]            = ref_src;
        lane_src[L_AGP0 +: N_AGP]   = {N_AGP{agp_src}};
    end

    clk_gate_bank #(.LANES(N_LANE)) u_gates (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (lane_src),
        .en    (lane_en),
        .gated (lane_out)
    );

    assign cpu_clk_t     = {lane_out[L_CPU_T1], lane_out[L_CPU_T0]};
    assign cpu_clk_c     = lane_out[L_CPU_C0];
    assign sdram_clk     = lane_out[L_SDRAM0 +: N_SDRAM];
    assign pci_clk       = lane_out[L_PCI0+1 +: N_PCI-1];
    assign agp_clk       = lane_out[L_AGP0 +: N_AGP];
    assign clk_24_48     = lane_out[L_CLK2448];
    assign strap_pad_oe  = drive_en;
    assign strap_pad_out = drive_en ? {lane_out[L_REF1], lane_out[L_REF0], lane_out[L_PCI0],
                                       lane_out[L_PCI_F], lane_out[L_CLK48]} : '0;
    assign fs_code       = strap_q[FS_W-1:0];
    assign agp_sel       = strap_q[STRAP_W-1];

    AST_RDBK_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_MISC) |-> (reg_rdata[REG_W-1:REG_W-FS_W] == ~fs_code)); // R4

endmodule

// File: tb/strap_clk_gate_top_tb.sv
`timescale 1ns/1ps
module strap_clk_gate_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_src = 1'b0, sdram_src = 1'b0, pci_src = 1'b0;
    logic       agp_src = 1'b0, ref_src = 1'b0, usb_src = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [4:0] strap_pad_in = 5'd0;
    logic [4:0] strap_pad_out;
    logic       strap_pad_oe;
    logic [1:0] cpu_clk_t;
    logic       cpu_clk_c;
    logic [12:0] sdram_clk;
    logic [3:0] pci_clk;
    logic [1:0] agp_clk;
    logic       clk_24_48;
    logic [3:0] fs_code;
    logic       agp_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] b1, b2, b3, b4;
    logic [3:0] b5;
    logic [3:0] fs_now;

    always #5 clk = ~clk;

    // ideal sources, all moved on the falling edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        cpu_src   <= ~cpu_src;
        sdram_src <= ~sdram_src;
        if (cyc % 3 == 0) pci_src <= ~pci_src;
        if (cyc % 2 == 0) begin
            agp_src <= ~agp_src;
            usb_src <= ~usb_src;
        end
        if (cyc % 5 == 0) ref_src <= ~ref_src;
    end

    strap_clk_gate_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_src(cpu_src), .sdram_src(sdram_src), .pci_src(pci_src),
        .agp_src(agp_src), .ref_src(ref_src), .usb_src(usb_src),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .strap_pad_in(strap_pad_in), .strap_pad_out(strap_pad_out),
        .strap_pad_oe(strap_pad_oe),
        .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c), .sdram_clk(sdram_clk),
        .pci_clk(pci_clk), .agp_clk(agp_clk), .clk_24_48(clk_24_48),
        .fs_code(fs_code), .agp_sel(agp_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            3'd1: b1 = d;
            3'd2: b2 = d;
            3'd3: b3 = d;
            3'd4: b4 = d;
            3'd5: b5 = d[3:0];
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd1: return b1;
            3'd2: return b2;
            3'd3: return b3;
            3'd4: return b4;
            3'd5: return {~fs_now, b5};
            default: return 8'h00;
        endcase
    endfunction

    task automatic rd_chk(input logic [2:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        reg_addr = a;
        #1;
        e = model_rd(a);
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic check_lanes(input string req);
        logic [4:0]  ep;
        logic [12:0] es;
        repeat (6) begin
            @(negedge clk);
            #2;
            chk(cpu_clk_t == ({b1[1], b1[3]} & {2{cpu_src}}), {req, " cpu_t"},
                cpu_clk_t, {b1[1], b1[3]} & {2{cpu_src}});
            chk(cpu_clk_c == (b1[2] & ~cpu_src), {req, " cpu_c"}, cpu_clk_c, b1[2] & ~cpu_src);
            es = {b4[4:0], b3} & {13{sdram_src}};
            chk(sdram_clk == es, {req, " sdram"}, sdram_clk, es);
            chk(pci_clk == (b2[5:2] & {4{pci_src}}), {req, " pci"}, pci_clk, b2[5:2] & {4{pci_src}});
            chk(agp_clk == (b5[1:0] & {2{agp_src}}), {req, " agp"}, agp_clk, b5[1:0] & {2{agp_src}});
            ep = {b5[3] & ref_src, b5[2] & ref_src, b2[1] & pci_src, b2[0] & pci_src, b4[5] & usb_src};
            chk(strap_pad_out == ep, {req, " pads"}, strap_pad_out, ep);
            if (!b1[7])
                chk(clk_24_48 == (b4[6] & usb_src), {req, " R8 full-rate"}, clk_24_48, b4[6] & usb_src);
        end
    endtask

    task automatic do_reset(input logic [4:0] pat);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pad_in = pat;
        repeat (3) @(negedge clk);
        chk(strap_pad_oe == 1'b0, "R2 oe in reset", strap_pad_oe, 0);
        chk(strap_pad_out == 5'd0, "R2 pads quiet", strap_pad_out, 0);
        rst_n = 1'b1;
        strap_pad_in = ~pat;   // R1: late pad changes must not matter
        @(posedge clk); #1;
        chk(strap_pad_oe == 1'b0, "R2 oe first edge", strap_pad_oe, 0);
        @(posedge clk); #1;
        chk(strap_pad_oe == 1'b1, "R2 oe second edge", strap_pad_oe, 1);
        b1 = 8'hFF; b2 = 8'hFF; b3 = 8'hFF; b4 = 8'hFF; b5 = 4'hF;
        fs_now = pat[3:0];
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 R2 R3 R4 R7: all 32 strap patterns
        for (int p = 0; p < 32; p++) begin
            do_reset(5'(p));
            chk(fs_code == 4'(p), "R3 R1 fs_code", fs_code, p & 15);
            chk(agp_sel == p[4], "R3 R1 agp_sel", agp_sel, p[4]);
            rd_chk(3'd5, "R4 R7 readback");
            for (int a = 1; a <= 4; a++) rd_chk(3'(a), "R7 reset value");
        end

        do_reset(5'b01010);

        // R8: default half rate
        begin
            int rises = 0;
            logic last = 1'b0;
            repeat (4) @(negedge clk);
            for (int k = 0; k < 64; k++) begin
                @(negedge clk); #2;
                if (clk_24_48 && !last) rises++;
                last = clk_24_48;
            end
            chk(rises >= 7 && rises <= 9, "R8 half rate rises", rises, 8);
        end
        check_lanes("R6 all enabled");

        // R5 R6 R10: single-bit walk and full clear, every address
        for (int a = 1; a <= 5; a++) begin
            for (int b = 0; b < ((a == 5) ? 4 : 8); b++) begin
                wr(3'(a), ~(8'd1 << b));
                rd_chk(3'(a), "R10 R5 readback");
                repeat (12) @(negedge clk);
                check_lanes("R5 R6 walk");
            end
            wr(3'(a), 8'h00);
            rd_chk(3'(a), "R10 zero");
            repeat (12) @(negedge clk);
            check_lanes("R6 byte off");
            wr(3'(a), 8'hFF);
            repeat (12) @(negedge clk);
        end

        // R4: upper nibble of address 5 ignores writes
        wr(3'd5, 8'h5F);
        rd_chk(3'd5, "R4 write ignored");

        // R10: unused addresses
        wr(3'd0, 8'h00);
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h00);
        rd_chk(3'd0, "R10 addr0");
        rd_chk(3'd6, "R10 addr6");
        rd_chk(3'd7, "R10 addr7");
        repeat (12) @(negedge clk);
        check_lanes("R10 no effect");

        // R9: disable REF0 pad in mid pulse
        @(posedge ref_src);
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h0B;
        @(negedge clk);
        reg_wr = 1'b0; b5 = 4'hB;
        #2;
        chk(strap_pad_out[3] == 1'b1, "R9 pulse kept", strap_pad_out[3], 1);
        @(negedge ref_src); #2;
        chk(strap_pad_out[3] == 1'b0, "R9 low after fall", strap_pad_out[3], 0);
        @(posedge ref_src); #2;
        chk(strap_pad_out[3] == 1'b0, "R9 stays off", strap_pad_out[3], 0);
        // re-enable while high: no partial pulse
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h0F;
        @(negedge clk);
        reg_wr = 1'b0; b5 = 4'hF;
        #2;
        chk(strap_pad_out[3] == 1'b0, "R9 no late rise", strap_pad_out[3], 0);
        repeat (12) @(negedge clk);
        check_lanes("R9 reenabled");

        // R8: rate toggled back and forth
        wr(3'd1, 8'h7F);
        repeat (12) @(negedge clk);
        check_lanes("R8 sel 48");
        wr(3'd1, 8'hFF);
        repeat (12) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule